// File: doc/BRIEF.md
# Command-Decoding I2C Register Target

This block is an I2C target that exposes a small register file held outside it. It watches the open-drain SCL and SDA lines, resynchronises them into the system clock domain, finds start and stop conditions, shifts bytes in and out and answers each byte with an acknowledge or a no-acknowledge by pulling SDA low or leaving it released. The first byte written after the address byte is decoded. A value inside the register range names the target of a one-byte write. Three reserved values instead start a pointer load, a counted block write or a counted block read.

The block keeps an address pointer that lasts across transactions. A one-byte read, a block write and a block read all begin at this pointer, and both block transfers move it forward. The register file sits outside the block. It sees a one-cycle write strobe with address and data, and it returns read data for the pointer address with no clock delay.

Top module: `i2c_cmd_regslave`

## Requirements
- R1: Only an address byte whose upper seven bits equal DEV_ADDR (default 7'h0D) is acknowledged. A frame with any other address gets no acknowledge and SDA is never driven until the next start. That frame causes no write and leaves the pointer unchanged.
- R2: A write frame whose first data byte is an in-range register index (value below RF_DEPTH) and is not a reserved code acknowledges both bytes. It stores the second byte at that index and leaves the pointer unchanged.
- R3: A register index at or above RF_DEPTH is not acknowledged in the byte that carries it. This holds for the one-byte write index and for the pointer-load value. No write follows and the pointer keeps its value.
- R4: The code 8'hB0 followed by an in-range index loads the pointer with that index. Both bytes are acknowledged.
- R5: A read frame that no block-read setup precedes returns the byte at the pointer. The data is sent MSB first and the pointer does not change.
- R6: The code 8'hA0 followed by a count byte N starts a block write. The next N data bytes are acknowledged and stored at the pointer, which advances by one after each stored byte and wraps from RF_DEPTH-1 to 0. Further data bytes are not acknowledged and not stored.
- R7: The code 8'hA1 followed by a nonzero count N, then a repeated start and a read address, returns N bytes from the pointer onward. The pointer ends N places further on, and SDA is released after the last byte. A count of zero is not acknowledged.
- R8: A stop or a start that arrives partway through a byte drops that byte. No write takes place.
- R9: The block changes its SDA drive only while SCL is low, and each write strobe lasts exactly one system clock cycle.
- R10: After reset the block leaves SDA released, the write strobe is low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| rf_we | output | 1 | Register-file write strobe, one cycle |
| rf_waddr | output | AW | Register-file write index |
| rf_wdata | output | 8 | Register-file write data |
| rf_raddr | output | AW | Register-file read index (the pointer) |
| rf_rdata | input | 8 | Register-file read data for rf_raddr, no clock delay |

## Verification
In a block write, the edge that stores a data byte also moves the pointer forward. When the pointer sits at the top of the register file, that same edge wraps it to zero. The bench loads the pointer at RF_DEPTH-2 and writes three bytes, so both the store and the wrap fall on one edge. It judges the result by reading each stored byte back through a pointer load and a one-byte read, and by checking that a later one-byte read returns index 1. A block read meets the same overlap: the pointer step comes on the acknowledge clock, and the next byte is loaded from that new pointer on the following falling edge. The returned sequence shows whether that ordering holds.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK,
        ST_IGN
    } bus_state_e;

    typedef enum logic [2:0] {
        K_ADDR,
        K_CMD,
        K_PTR,
        K_BWCNT,
        K_BWDATA,
        K_BRCNT,
        K_WDATA,
        K_NONE
    } byte_kind_e;

    localparam logic [7:0] CODE_BLK_WR  = 8'hA0;
    localparam logic [7:0] CODE_BLK_RD  = 8'hA1;
    localparam logic [7:0] CODE_PTR_SET = 8'hB0;

endpackage

// File: rtl/i2c_sync2.sv
module i2c_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-2:0], d};
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_p_q, sda_p_q;

    i2c_sync2 #(.STAGES(SYNC_STAGES)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
    i2c_sync2 #(.STAGES(SYNC_STAGES)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_s;
            sda_p_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p_q;
    assign scl_fall  = ~scl_s & scl_p_q;
    assign start_det = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_det  = scl_s & scl_p_q & ~sda_p_q & sda_s;
endmodule

// File: rtl/i2c_cmd_regslave.sv
module i2c_cmd_regslave
    import i2c_cmd_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h0D,
    parameter int         RF_DEPTH    = 16,
    parameter int         SYNC_STAGES = 2,
    localparam int        AW          = $clog2(RF_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic          rf_we,
    output logic [AW-1:0] rf_waddr,
    output logic [7:0]    rf_wdata,
    output logic [AW-1:0] rf_raddr,
    input  logic [7:0]    rf_rdata
);
    localparam logic [8:0]    DEPTH9 = 9'(RF_DEPTH);
    localparam logic [AW-1:0] TOP_IX = AW'(RF_DEPTH - 1);

    typedef struct packed {
        bus_state_e    st;
        byte_kind_e    kind;
        byte_kind_e    nxt;
        logic [3:0]    bitcnt;
        logic [7:0]    sh;
        logic          ack;
        logic          go_tx;
        logic          oe;
        logic [AW-1:0] ptr;
        logic [AW-1:0] waddr;
        logic [7:0]    wdata;
        logic          we;
        logic [7:0]    cnt;
        logic          rd_pend;
        logic          blk;
        logic          mack;
    } regs_t;

    regs_t r_d, r_q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det));

    logic [7:0]    byte_in;
    logic          in_rng;
    logic [AW-1:0] ptr_nx;

    assign byte_in = {r_q.sh[6:0], sda_s};
    assign in_rng  = ({1'b0, byte_in} < DEPTH9);
    assign ptr_nx  = (r_q.ptr == TOP_IX) ? '0 : r_q.ptr + AW'(1);

    always_comb begin
        r_d    = r_q;
        r_d.we = 1'b0;
        if (stop_det) begin
            r_d.st      = ST_IDLE;
            r_d.oe      = 1'b0;
            r_d.go_tx   = 1'b0;
            r_d.rd_pend = 1'b0;
        end else if (start_det) begin
            r_d.st     = ST_RX;
            r_d.kind   = K_ADDR;
            r_d.bitcnt = 4'd0;
            r_d.oe     = 1'b0;
            r_d.go_tx  = 1'b0;
        end else begin
            case (r_q.st)
                ST_RX: begin
                    if (scl_rise && r_q.bitcnt != 4'd8) begin
                        r_d.sh     = byte_in;
                        r_d.bitcnt = r_q.bitcnt + 4'd1;
                        if (r_q.bitcnt == 4'd7) begin
                            r_d.ack   = 1'b0;
                            r_d.go_tx = 1'b0;
                            r_d.nxt   = K_NONE;
                            case (r_q.kind)
                                K_ADDR: if (byte_in[7:1] == DEV_ADDR) begin
                                    r_d.ack     = 1'b1;
                                    r_d.rd_pend = 1'b0;
                                    if (byte_in[0]) begin
                                        r_d.go_tx = 1'b1;
                                        r_d.blk   = r_q.rd_pend;
                                        r_d.cnt   = r_q.rd_pend ? r_q.cnt : 8'd1;
                                    end else begin
                                        r_d.nxt = K_CMD;
                                    end
                                end
                                K_CMD: begin
                                    if (byte_in == CODE_BLK_WR) begin
                                        r_d.ack = 1'b1;
                                        r_d.nxt = K_BWCNT;
                                    end else if (byte_in == CODE_BLK_RD) begin
                                        r_d.ack = 1'b1;
                                        r_d.nxt = K_BRCNT;
                                    end else if (byte_in == CODE_PTR_SET) begin
                                        r_d.ack = 1'b1;
                                        r_d.nxt = K_PTR;
                                    end else if (in_rng) begin
                                        r_d.ack   = 1'b1;
                                        r_d.waddr = byte_in[AW-1:0];
                                        r_d.nxt   = K_WDATA;
                                    end
                                end
                                K_PTR: if (in_rng) begin
                                    r_d.ack = 1'b1;
                                    r_d.ptr = byte_in[AW-1:0];
                                end
                                K_BWCNT: begin
                                    r_d.ack = 1'b1;
                                    r_d.cnt = byte_in;
                                    r_d.nxt = K_BWDATA;
                                end
                                K_BWDATA: if (r_q.cnt != 8'd0) begin
                                    r_d.ack   = 1'b1;
                                    r_d.we    = 1'b1;
                                    r_d.waddr = r_q.ptr;
                                    r_d.wdata = byte_in;
                                    r_d.ptr   = ptr_nx;
                                    r_d.cnt   = r_q.cnt - 8'd1;
                                    r_d.nxt   = K_BWDATA;
                                end
                                K_BRCNT: if (byte_in != 8'd0) begin
                                    r_d.ack     = 1'b1;
                                    r_d.cnt     = byte_in;
                                    r_d.rd_pend = 1'b1;
                                end
                                K_WDATA: begin
                                    r_d.ack   = 1'b1;
                                    r_d.we    = 1'b1;
                                    r_d.wdata = byte_in;
                                end
                                default: ;
                            endcase
                        end
                    end else if (scl_fall && r_q.bitcnt == 4'd8) begin
                        r_d.oe = r_q.ack;
                        r_d.st = r_q.ack ? ST_ACK : ST_IGN;
                    end
                end
                ST_ACK: if (scl_fall) begin
                    r_d.bitcnt = 4'd0;
                    if (r_q.go_tx) begin
                        r_d.sh = rf_rdata;
                        r_d.oe = ~rf_rdata[7];
                        r_d.st = ST_TX;
                    end else begin
                        r_d.oe   = 1'b0;
                        r_d.kind = r_q.nxt;
                        r_d.st   = (r_q.nxt == K_NONE) ? ST_IGN : ST_RX;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        r_d.bitcnt = r_q.bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (r_q.bitcnt == 4'd8) begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_RACK;
                        end else begin
                            r_d.sh = {r_q.sh[6:0], 1'b0};
                            r_d.oe = ~r_q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        r_d.mack = ~sda_s;
                        r_d.cnt  = r_q.cnt - 8'd1;
                        if (r_q.blk) r_d.ptr = ptr_nx;
                    end else if (scl_fall) begin
                        if (r_q.mack && r_q.cnt != 8'd0) begin
                            r_d.sh     = rf_rdata;
                            r_d.oe     = ~rf_rdata[7];
                            r_d.bitcnt = 4'd0;
                            r_d.st     = ST_TX;
                        end else begin
                            r_d.st = ST_IGN;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sda_oe   = r_q.oe;
    assign rf_we    = r_q.we;
    assign rf_waddr = r_q.waddr;
    assign rf_wdata = r_q.wdata;
    assign rf_raddr = r_q.ptr;

    AST_OE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(r_q.oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_s) // R9
        else $error("sda drive changed while SCL high");
    AST_WE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we) // R9
        else $error("write strobe longer than one cycle");
    AST_WADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> ({1'b0, 8'(rf_waddr)} < DEPTH9)) // R3
        else $error("write outside register file");
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE || r_q.st == ST_IGN) |-> !sda_oe) // R1
        else $error("SDA driven while idle or ignoring");
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && !rf_we)) // R8
        else $error("activity after stop");
endmodule

// File: tb/i2c_cmd_regslave_bench.sv
module i2c_cmd_regslave_bench;
    localparam int         RF_DEPTH = 16;
    localparam int         AW       = $clog2(RF_DEPTH);
    localparam logic [6:0] DEV      = 7'h0D;
    localparam int         Q        = 5;
    localparam int         H        = 10;
    localparam logic [15:0] VEC [6] = '{16'h01A5, 16'h0A3C, 16'h0F81,
                                        16'h0600, 16'h0BFF, 16'h0D5E};

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n;
    logic          m_scl_low, m_sda_low;
    logic          sda_oe, rf_we;
    logic [AW-1:0] rf_waddr, rf_raddr;
    logic [7:0]    rf_wdata, rf_rdata;
    logic [7:0]    mem  [RF_DEPTH];
    logic [7:0]    expv [RF_DEPTH];
    wire           scl_line = !m_scl_low;
    wire           sda_line = !(m_sda_low | sda_oe);

    int n_chk = 0, n_fail = 0, viol_scl = 0, viol_we = 0, drives = 0;
    logic prev_oe, prev_we;

    i2c_cmd_regslave #(.DEV_ADDR(DEV), .RF_DEPTH(RF_DEPTH)) u_i2c_cmd_regslave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .sda_oe(sda_oe), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < RF_DEPTH; i++) mem[i] <= 8'(8'h10 + i * 7);
        end else if (rf_we) begin
            mem[rf_waddr] <= rf_wdata;
        end
    end
    assign rf_rdata = mem[rf_raddr];

    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_line && sda_oe !== prev_oe) viol_scl++;
            if (rf_we && prev_we) viol_we++;
            if (sda_oe) drives++;
        end
        prev_oe = sda_oe;
        prev_we = rf_we;
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        m_sda_low = !b; wt(Q);
        m_scl_low = 1'b0; wt(H);
        m_scl_low = 1'b1; wt(Q);
    endtask

    task automatic i2c_start();
        m_sda_low = 1'b0; wt(Q);
        m_scl_low = 1'b0; wt(H);
        m_sda_low = 1'b1; wt(H);
        m_scl_low = 1'b1; wt(Q);
    endtask

    task automatic i2c_stop();
        m_sda_low = 1'b1; wt(Q);
        m_scl_low = 1'b0; wt(H);
        m_sda_low = 1'b0; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        m_sda_low = 1'b0; wt(Q);
        m_scl_low = 1'b0; wt(H / 2);
        ack = !sda_line; wt(H / 2);
        m_scl_low = 1'b1; wt(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack);
        m_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wt(Q);
            m_scl_low = 1'b0; wt(H / 2);
            b[i] = sda_line; wt(H / 2);
            m_scl_low = 1'b1; wt(Q);
        end
        m_sda_low = mack; wt(Q);
        m_scl_low = 1'b0; wt(H);
        m_scl_low = 1'b1; wt(Q);
        m_sda_low = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d, output logic [2:0] acks);
        i2c_start();
        send_byte({DEV, 1'b0}, acks[2]);
        send_byte(a, acks[1]);
        send_byte(d, acks[0]);
        i2c_stop();
    endtask

    task automatic set_ptr(input logic [7:0] a, output logic [2:0] acks);
        i2c_start();
        send_byte({DEV, 1'b0}, acks[2]);
        send_byte(8'hB0, acks[1]);
        send_byte(a, acks[0]);
        i2c_stop();
    endtask

    task automatic rd_single(output logic [7:0] d, output logic ack);
        i2c_start();
        send_byte({DEV, 1'b1}, ack);
        recv_byte(d, 1'b0);
        i2c_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [2:0] a3;
        logic [6:0] a7;
        logic [7:0] d, d0, d1, d2;
        logic       a;
        for (int i = 0; i < RF_DEPTH; i++) expv[i] = 8'(8'h10 + i * 7);
        m_scl_low = 1'b0; m_sda_low = 1'b0;
        rst_n = 1'b0;
        wt(10);
        chk("R10 sda released in reset", {31'd0, sda_oe}, 0);
        chk("R10 no write in reset", {31'd0, rf_we}, 0);
        rst_n = 1'b1;
        wt(10);

        rd_single(d, a);
        chk("R10 pointer zero after reset", {24'd0, d}, {24'd0, expv[0]});
        chk("R1 own address acked", {31'd0, a}, 1);

        // table walk: R2 write, R4 pointer load, R5 read back
        for (int v = 0; v < 6; v++) begin
            wr_reg(VEC[v][15:8], VEC[v][7:0], a3);
            chk("R2 single write acks", {29'd0, a3}, 3'b111);
            expv[VEC[v][11:8]] = VEC[v][7:0];
            set_ptr(VEC[v][15:8], a3);
            chk("R4 pointer load acks", {29'd0, a3}, 3'b111);
            rd_single(d, a);
            chk("R5 read at pointer", {24'd0, d}, {24'd0, VEC[v][7:0]});
        end

        set_ptr(8'd3, a3);
        wr_reg(8'd9, 8'hC3, a3);
        expv[9] = 8'hC3;
        rd_single(d, a);
        chk("R2 pointer unchanged by single write", {24'd0, d}, {24'd0, expv[3]});
        rd_single(d, a);
        chk("R5 repeated read same byte", {24'd0, d}, {24'd0, expv[3]});

        // R1 foreign address
        set_ptr(8'd4, a3);
        drives = 0;
        i2c_start();
        send_byte(8'h44, a);
        chk("R1 foreign address not acked", {31'd0, a}, 0);
        send_byte(8'h04, a);
        send_byte(8'h77, a);
        i2c_stop();
        chk("R1 SDA never driven", drives, 0);
        rd_single(d, a);
        chk("R1 no side effect", {24'd0, d}, {24'd0, expv[4]});

        // R3 out of range index
        i2c_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h20, a);
        chk("R3 write index out of range nacked", {31'd0, a}, 0);
        i2c_stop();
        set_ptr(8'h30, a3);
        chk("R3 pointer value out of range nacked", {29'd0, a3}, 3'b110);
        rd_single(d, a);
        chk("R3 pointer kept", {24'd0, d}, {24'd0, expv[4]});

        // R6 block write across the top of the file
        set_ptr(8'd14, a3);
        i2c_start();
        send_byte({DEV, 1'b0}, a3[2]);
        send_byte(8'hA0, a3[1]);
        send_byte(8'd3, a3[0]);
        chk("R6 block write header acks", {29'd0, a3}, 3'b111);
        send_byte(8'h61, a3[2]);
        send_byte(8'h62, a3[1]);
        send_byte(8'h63, a3[0]);
        send_byte(8'h64, a);
        i2c_stop();
        chk("R6 data acks then nack past count", {28'd0, a3, a}, 4'b1110);
        expv[14] = 8'h61; expv[15] = 8'h62; expv[0] = 8'h63;
        rd_single(d, a);
        chk("R6 pointer wrapped to 1", {24'd0, d}, {24'd0, expv[1]});
        set_ptr(8'd15, a3);
        rd_single(d, a);
        chk("R6 byte at top index", {24'd0, d}, {24'd0, expv[15]});
        set_ptr(8'd0, a3);
        rd_single(d, a);
        chk("R6 wrapped byte at index 0", {24'd0, d}, {24'd0, expv[0]});

        // R7 block read
        set_ptr(8'd2, a3);
        i2c_start();
        send_byte({DEV, 1'b0}, a3[2]);
        send_byte(8'hA1, a3[1]);
        send_byte(8'd3, a3[0]);
        i2c_start();
        send_byte({DEV, 1'b1}, a);
        chk("R7 block read setup acks", {28'd0, a3, a}, 4'b1111);
        recv_byte(d0, 1'b1);
        recv_byte(d1, 1'b1);
        recv_byte(d2, 1'b0);
        i2c_stop();
        chk("R7 block read bytes", {8'd0, d0, d1, d2}, {8'd0, expv[2], expv[3], expv[4]});
        rd_single(d, a);
        chk("R7 pointer advanced by count", {24'd0, d}, {24'd0, expv[5]});
        i2c_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'hA1, a);
        send_byte(8'd0, a);
        i2c_stop();
        chk("R7 zero count nacked", {31'd0, a}, 0);

        // R8 stop inside a data byte
        i2c_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'd8, a);
        for (int i = 0; i < 4; i++) bit_out(1'b1);
        i2c_stop();
        set_ptr(8'd8, a3);
        rd_single(d, a);
        chk("R8 partial byte not written", {24'd0, d}, {24'd0, expv[8]});
        a7 = 7'd0;
        chk("R8 pointer load after abort acked", {29'd0, a3}, 3'b111);

        chk("R9 no drive change while SCL high", viol_scl, {25'd0, a7});
        chk("R9 write strobe one cycle", viol_we, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule